// File: doc/BRIEF.md
# Vertical-Blanking Caption and Copy-Control Line Inserter

This block produces the digital data waveform carried on selected vertical-blanking lines of a video output. It carries two services: a two-byte closed-caption payload and a 20-bit copy-generation control (CGMS) word. Each service has its own enable, target line number and target field. When a start-of-line strobe arrives for a line and field that match a service, the block waits a programmed number of system clocks. It then shifts that service's bits out, one bit every programmed bit period. For each sample it reports whether data is active and whether the level is high or black. A downstream mixer turns this into analog amplitude. Run-in clock shaping and CRC generation are not done here. The writer supplies the CGMS CRC bits inside the 20-bit word, and the caption parity bits inside each byte.

Caption bytes are loaded with a strobe and sit in a holding register. With gating on, which is the normal mode, a freshly loaded pair goes out on exactly one caption line, that is, for one frame. After that the null pair 0x80/0x80 is sent until new bytes arrive. A registered pending flag shows that loaded bytes have not yet been sent.

Top module: `vbi_data_inserter`

## Requirements
- R1: After synchronous reset, `data_active`, `level_hi` and `cc_pending` are 0, and the caption holding register holds the null pair (0x80, 0x80).
- R2: A service is emitted on a line only when its enable is 1, `line_num` equals its configured line and `field_id` equals its configured field. Any other line produces no active samples.
- R3: If `line_start` is sampled at clock edge E, the first bit appears on the outputs after edge E+`start_ofs`+1. Each bit is held for `bit_period` clocks; a `bit_period` of 0 acts as 1. The burst lasts exactly bits×period clocks.
- R4: A caption line sends 16 bits: `cc_byte_a` least significant bit first, then `cc_byte_b` least significant bit first. A 1 bit gives `level_hi`=1, a 0 bit gives 0, and `level_hi` is 0 whenever `data_active` is 0.
- R5: A CGMS line sends 20 bits with `cgms_word[0]` (bit 1) first and `cgms_word[19]` (bit 20) last, exactly as supplied, with no CRC computed.
- R6: With `cc_gate_en`=1, loaded bytes are sent on the next matching caption line only. Later caption lines carry 0x80, 0x80 until a new load.
- R7: With `cc_gate_en`=0, every caption line repeats the last loaded pair.
- R8: `cc_load` sets `cc_pending` on the next clock. A caption line start clears it. If a load coincides with a caption line start, that line carries the data held before the load and `cc_pending` stays 1.
- R9: If both services match the same line, the caption is sent and the CGMS word is not.
- R10: A `line_start` ends any burst in progress. If the new line matches no service, `data_active` is 0 after that edge.
- R11: Caption bytes are sent as written; the parity bit in each byte's MSB is neither checked nor corrected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-clock strobe at the start of each line |
| line_num | input | LINE_W | Number of the line that is starting |
| field_id | input | 1 | Field of the line that is starting |
| cc_en | input | 1 | Caption service enable |
| cc_line | input | LINE_W | Caption target line |
| cc_field | input | 1 | Caption target field |
| cc_gate_en | input | 1 | 1: send loaded pair once, then null |
| cc_load | input | 1 | Caption byte load strobe |
| cc_byte_a | input | 8 | First caption byte (with parity) |
| cc_byte_b | input | 8 | Second caption byte (with parity) |
| cgms_en | input | 1 | CGMS service enable |
| cgms_line | input | LINE_W | CGMS target line |
| cgms_field | input | 1 | CGMS target field |
| cgms_word | input | 20 | CGMS word, bit 0 sent first, CRC included |
| bit_period | input | PER_W | Clocks per data bit (0 acts as 1) |
| start_ofs | input | OFS_W | Clocks from line strobe to first bit |
| data_active | output | 1 | A data bit is being output |
| level_hi | output | 1 | 1 = high data level, 0 = black |
| cc_pending | output | 1 | Loaded caption bytes not yet sent |

## Verification
The bench builds the block with its defaults: a 10-bit line number, an 8-bit bit period and a 10-bit start offset. That covers the line counts of both common scan standards. Small offsets and periods are chosen at run time so that whole bursts fit in a few hundred clocks. The zero-period case and a mid-burst restart are still reachable. Across the runs, every sample of each burst is compared with the expected bit, both bit orders are checked, and the gating sequence with its load-collision case is followed through several lines.

// File: rtl/vbi_pkg.sv
package vbi_pkg;
  localparam int N_SVC     = 2;
  localparam int SVC_CC    = 0;
  localparam int SVC_CGMS  = 1;
  localparam int CC_BITS   = 16;
  localparam int CGMS_BITS = 20;
  localparam int MAX_BITS  = (CGMS_BITS > CC_BITS) ? CGMS_BITS : CC_BITS;
  localparam int CNT_W     = $clog2(MAX_BITS + 1);
  localparam logic [7:0] CC_NULL_BYTE = 8'h80;

  typedef enum logic [1:0] {
    SER_IDLE = 2'd0,
    SER_WAIT = 2'd1,
    SER_SEND = 2'd2
  } ser_state_e;
endpackage

// File: rtl/vbi_line_match.sv
module vbi_line_match #(
  parameter int LINE_W = 10
) (
  input  logic              en,
  input  logic [LINE_W-1:0] cfg_line,
  input  logic              cfg_field,
  input  logic [LINE_W-1:0] line_num,
  input  logic              field_id,
  output logic              hit
);
  always_comb begin
    hit = en && (line_num == cfg_line) && (field_id == cfg_field);
  end
endmodule

// File: rtl/vbi_cc_gate.sv
module vbi_cc_gate
  import vbi_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [7:0]         byte_a,
  input  logic [7:0]         byte_b,
  input  logic               gate_en,
  input  logic               take,
  output logic [CC_BITS-1:0] word,
  output logic               pending
);
  localparam logic [CC_BITS-1:0] NULL_WORD = {CC_NULL_BYTE, CC_NULL_BYTE};

  logic [CC_BITS-1:0] held;

  always_ff @(posedge clk) begin
    if (rst) begin
      held    <= NULL_WORD;
      pending <= 1'b0;
    end else if (load) begin
      held    <= {byte_b, byte_a};
      pending <= 1'b1;
    end else if (take) begin
      pending <= 1'b0;
    end
  end

  // word seen by a line start this cycle reflects state before any same-cycle load
  always_comb begin
    word = (pending || !gate_en) ? held : NULL_WORD;
  end

  assert_load_sets_pending_R8: assert property (@(posedge clk) disable iff (rst)
    load |=> pending);
  assert_take_clears_pending_R8: assert property (@(posedge clk) disable iff (rst)
    (take && !load) |=> !pending);
endmodule

// File: rtl/vbi_serializer.sv
module vbi_serializer
  import vbi_pkg::*;
#(
  parameter int PER_W = 8,
  parameter int OFS_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                line_start,
  input  logic                go,
  input  logic [MAX_BITS-1:0] word,
  input  logic [CNT_W-1:0]    nbits,
  input  logic [PER_W-1:0]    bit_period,
  input  logic [OFS_W-1:0]    start_ofs,
  output logic                active,
  output logic                level
);
  ser_state_e          state;
  logic [MAX_BITS-1:0] shreg;
  logic [OFS_W-1:0]    ofs_cnt;
  logic [PER_W-1:0]    per_cnt;
  logic [CNT_W-1:0]    bits_left;
  logic [PER_W-1:0]    eff_per;

  always_comb begin
    eff_per = (bit_period == '0) ? PER_W'(1) : bit_period;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SER_IDLE;
      shreg     <= '0;
      ofs_cnt   <= '0;
      per_cnt   <= '0;
      bits_left <= '0;
      active    <= 1'b0;
      level     <= 1'b0;
    end else if (line_start) begin
      active <= 1'b0;
      level  <= 1'b0;
      if (go) begin
        state     <= SER_WAIT;
        shreg     <= word;
        bits_left <= nbits;
        ofs_cnt   <= start_ofs;
      end else begin
        state <= SER_IDLE;
      end
    end else begin
      case (state)
        SER_WAIT: begin
          if (ofs_cnt == '0) begin
            state   <= SER_SEND;
            active  <= 1'b1;
            level   <= shreg[0];
            per_cnt <= eff_per - 1'b1;
          end else begin
            ofs_cnt <= ofs_cnt - 1'b1;
          end
        end
        SER_SEND: begin
          if (per_cnt == '0) begin
            if (bits_left == CNT_W'(1)) begin
              state  <= SER_IDLE;
              active <= 1'b0;
              level  <= 1'b0;
            end else begin
              shreg     <= shreg >> 1;
              level     <= shreg[1];
              bits_left <= bits_left - 1'b1;
              per_cnt   <= eff_per - 1'b1;
            end
          end else begin
            per_cnt <= per_cnt - 1'b1;
          end
        end
        default: begin
          active <= 1'b0;
          level  <= 1'b0;
        end
      endcase
    end
  end

  assert_idle_level_black_R4: assert property (@(posedge clk) disable iff (rst)
    !active |-> !level);
  assert_bit_held_R3: assert property (@(posedge clk) disable iff (rst)
    (state == SER_SEND && per_cnt != '0 && !line_start) |=> (active && $stable(level)));
  assert_restart_ends_burst_R10: assert property (@(posedge clk) disable iff (rst)
    (line_start && !go) |=> !active);
endmodule

// File: rtl/vbi_data_inserter.sv
module vbi_data_inserter
  import vbi_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int PER_W  = 8,
  parameter int OFS_W  = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 line_start,
  input  logic [LINE_W-1:0]    line_num,
  input  logic                 field_id,
  input  logic                 cc_en,
  input  logic [LINE_W-1:0]    cc_line,
  input  logic                 cc_field,
  input  logic                 cc_gate_en,
  input  logic                 cc_load,
  input  logic [7:0]           cc_byte_a,
  input  logic [7:0]           cc_byte_b,
  input  logic                 cgms_en,
  input  logic [LINE_W-1:0]    cgms_line,
  input  logic                 cgms_field,
  input  logic [CGMS_BITS-1:0] cgms_word,
  input  logic [PER_W-1:0]     bit_period,
  input  logic [OFS_W-1:0]     start_ofs,
  output logic                 data_active,
  output logic                 level_hi,
  output logic                 cc_pending
);
  logic [N_SVC-1:0]  svc_en;
  logic [N_SVC-1:0]  svc_field;
  logic [LINE_W-1:0] svc_line [N_SVC];
  logic [N_SVC-1:0]  hit;

  assign svc_en[SVC_CC]      = cc_en;
  assign svc_en[SVC_CGMS]    = cgms_en;
  assign svc_field[SVC_CC]   = cc_field;
  assign svc_field[SVC_CGMS] = cgms_field;
  assign svc_line[SVC_CC]    = cc_line;
  assign svc_line[SVC_CGMS]  = cgms_line;

  for (genvar g = 0; g < N_SVC; g++) begin : g_match
    vbi_line_match #(.LINE_W(LINE_W)) u_match (
      .en        (svc_en[g]),
      .cfg_line  (svc_line[g]),
      .cfg_field (svc_field[g]),
      .line_num  (line_num),
      .field_id  (field_id),
      .hit       (hit[g])
    );
  end

  logic               cc_take;
  logic [CC_BITS-1:0] cc_word;

  assign cc_take = line_start && hit[SVC_CC];

  vbi_cc_gate u_gate (
    .clk     (clk),
    .rst     (rst),
    .load    (cc_load),
    .byte_a  (cc_byte_a),
    .byte_b  (cc_byte_b),
    .gate_en (cc_gate_en),
    .take    (cc_take),
    .word    (cc_word),
    .pending (cc_pending)
  );

  logic [MAX_BITS-1:0] ser_word;
  logic [CNT_W-1:0]    ser_nbits;

  // caption has priority when both services select the same line
  always_comb begin
    if (hit[SVC_CC]) begin
      ser_word  = MAX_BITS'(cc_word);
      ser_nbits = CNT_W'(CC_BITS);
    end else begin
      ser_word  = MAX_BITS'(cgms_word);
      ser_nbits = CNT_W'(CGMS_BITS);
    end
  end

  vbi_serializer #(.PER_W(PER_W), .OFS_W(OFS_W)) u_ser (
    .clk        (clk),
    .rst        (rst),
    .line_start (line_start),
    .go         (|hit),
    .word       (ser_word),
    .nbits      (ser_nbits),
    .bit_period (bit_period),
    .start_ofs  (start_ofs),
    .active     (data_active),
    .level      (level_hi)
  );

  assert_no_match_no_data_R2: assert property (@(posedge clk) disable iff (rst)
    (line_start && !cc_en && !cgms_en) |=> !data_active);
endmodule

// File: tb/vbi_data_inserter_bench.sv
`timescale 1ns/1ps
module vbi_data_inserter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        line_start = 1'b0;
  logic [9:0]  line_num = '0;
  logic        field_id = 1'b0;
  logic        cc_en = 1'b1;
  logic [9:0]  cc_line = 10'd21;
  logic        cc_field = 1'b0;
  logic        cc_gate_en = 1'b1;
  logic        cc_load = 1'b0;
  logic [7:0]  cc_byte_a = '0;
  logic [7:0]  cc_byte_b = '0;
  logic        cgms_en = 1'b1;
  logic [9:0]  cgms_line = 10'd20;
  logic        cgms_field = 1'b1;
  logic [19:0] cgms_word = 20'h93A5C;
  logic [7:0]  bit_period = 8'd1;
  logic [9:0]  start_ofs = '0;
  logic        data_active;
  logic        level_hi;
  logic        cc_pending;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vbi_data_inserter u_vbi_data_inserter (
    .clk, .rst, .line_start, .line_num, .field_id,
    .cc_en, .cc_line, .cc_field, .cc_gate_en, .cc_load, .cc_byte_a, .cc_byte_b,
    .cgms_en, .cgms_line, .cgms_field, .cgms_word,
    .bit_period, .start_ofs, .data_active, .level_hi, .cc_pending
  );

  typedef struct packed {
    logic [9:0]  line;
    logic        fld;
    logic [7:0]  ofs;
    logic [7:0]  per;
    logic [1:0]  kind;   // 0 none, 1 caption (16 bits), 2 CGMS (20 bits)
    logic [19:0] exp;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VEC [NVEC] = '{
    '{10'd21, 1'b0, 8'd5, 8'd3, 2'd1, 20'h0C241},  // loaded pair, parity as written
    '{10'd21, 1'b0, 8'd2, 8'd1, 2'd1, 20'h08080},  // gated: null pair
    '{10'd21, 1'b1, 8'd2, 8'd2, 2'd0, 20'h00000},  // wrong field
    '{10'd20, 1'b1, 8'd4, 8'd2, 2'd2, 20'h93A5C},  // CGMS word
    '{10'd20, 1'b0, 8'd1, 8'd1, 2'd0, 20'h00000},  // CGMS wrong field
    '{10'd22, 1'b0, 8'd1, 8'd1, 2'd0, 20'h00000}   // unmatched line
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load_cc(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    cc_load = 1'b1; cc_byte_a = a; cc_byte_b = b;
    @(negedge clk);
    cc_load = 1'b0;
  endtask

  // Drives one line strobe (optionally with a caption load) and checks the burst.
  task automatic run_line(input logic [9:0] ln, input logic fld, input int ofs, input int per,
                          input int nb, input logic [19:0] exp, input bit with_load,
                          input logic [7:0] la, input logic [7:0] lb, input string tag);
    int pe;
    int first;
    int acount;
    int bad;
    pe = (per == 0) ? 1 : per;
    @(negedge clk);
    start_ofs = 10'(ofs); bit_period = 8'(per);
    line_start = 1'b1; line_num = ln; field_id = fld;
    if (with_load) begin
      cc_load = 1'b1; cc_byte_a = la; cc_byte_b = lb;
    end
    @(negedge clk);
    line_start = 1'b0; cc_load = 1'b0;
    first = -1; acount = 0; bad = 0;
    for (int j = 1; j <= ofs + 3 + 20 * pe; j++) begin
      @(negedge clk);
      if (data_active) begin
        int idx;
        if (first < 0) first = j;
        idx = (j - first) / pe;
        acount++;
        if (idx >= nb || idx > 19) bad++;
        else if (level_hi !== exp[idx]) bad++;
      end else if (level_hi !== 1'b0) begin
        bad++;
      end
    end
    if (nb == 0) begin
      check(acount == 0, {tag, " R2 no burst"}, acount, 0);
    end else begin
      check(first == ofs + 1, {tag, " R3 start cycle"}, first, ofs + 1);
      check(acount == nb * pe, {tag, " R3 burst length"}, acount, nb * pe);
      check(bad == 0, {tag, " R4 R5 bit samples"}, bad, 0);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(data_active == 1'b0, "R1 data_active", data_active, 0);
    check(level_hi == 1'b0, "R1 level_hi", level_hi, 0);
    check(cc_pending == 1'b0, "R1 cc_pending", cc_pending, 0);
    // R1 held pair is null: gate off sends it before any load
    cc_gate_en = 1'b0;
    run_line(10'd21, 1'b0, 1, 1, 16, 20'h08080, 1'b0, 8'h00, 8'h00, "R1 null held");
    cc_gate_en = 1'b1;

    // table walk; 0x41 carries wrong parity on purpose (R11)
    load_cc(8'h41, 8'hC2);
    for (int v = 0; v < NVEC; v++) begin
      int nb;
      nb = (VEC[v].kind == 2'd1) ? 16 : (VEC[v].kind == 2'd2) ? 20 : 0;
      run_line(VEC[v].line, VEC[v].fld, int'(VEC[v].ofs), int'(VEC[v].per), nb,
               VEC[v].exp, 1'b0, 8'h00, 8'h00, $sformatf("vec%0d R6 R11", v));
    end

    // R8 pending set then cleared by the caption line
    load_cc(8'h15, 8'h97);
    check(cc_pending == 1'b1, "R8 pending after load", cc_pending, 1);
    run_line(10'd21, 1'b0, 0, 2, 16, 20'h09715, 1'b0, 8'h00, 8'h00, "R6 fresh pair");
    check(cc_pending == 1'b0, "R8 pending after send", cc_pending, 0);

    // R7 gate off repeats held pair; R6 gate on gives null
    cc_gate_en = 1'b0;
    run_line(10'd21, 1'b0, 3, 1, 16, 20'h09715, 1'b0, 8'h00, 8'h00, "R7 repeat");
    run_line(10'd21, 1'b0, 3, 1, 16, 20'h09715, 1'b0, 8'h00, 8'h00, "R7 repeat again");
    cc_gate_en = 1'b1;
    run_line(10'd21, 1'b0, 3, 1, 16, 20'h08080, 1'b0, 8'h00, 8'h00, "R6 null after");

    // R8 load colliding with caption line start
    run_line(10'd21, 1'b0, 1, 1, 16, 20'h08080, 1'b1, 8'h2A, 8'hAB, "R8 collision");
    check(cc_pending == 1'b1, "R8 pending kept on collision", cc_pending, 1);
    run_line(10'd21, 1'b0, 1, 1, 16, 20'h0AB2A, 1'b0, 8'h00, 8'h00, "R8 next line");

    // R9 both services on one line
    cgms_line = 10'd21; cgms_field = 1'b0;
    run_line(10'd21, 1'b0, 2, 1, 16, 20'h08080, 1'b0, 8'h00, 8'h00, "R9 priority");
    cgms_line = 10'd20; cgms_field = 1'b1;

    // R2 enables
    cc_en = 1'b0;
    run_line(10'd21, 1'b0, 1, 1, 0, 20'h0, 1'b0, 8'h00, 8'h00, "R2 cc disabled");
    cc_en = 1'b1;
    cgms_en = 1'b0;
    run_line(10'd20, 1'b1, 1, 1, 0, 20'h0, 1'b0, 8'h00, 8'h00, "R2 cgms disabled");
    cgms_en = 1'b1;

    // R3 zero period acts as one; R5 different word
    cgms_word = 20'h5F0E1;
    run_line(10'd20, 1'b1, 0, 0, 20, 20'h5F0E1, 1'b0, 8'h00, 8'h00, "R3 zero period");

    // R10 restart mid-burst on unmatched line
    @(negedge clk);
    start_ofs = '0; bit_period = 8'd10;
    line_start = 1'b1; line_num = 10'd21; field_id = 1'b0;
    @(negedge clk);
    line_start = 1'b0;
    repeat (20) @(negedge clk);
    check(data_active == 1'b1, "R10 burst running", data_active, 1);
    line_start = 1'b1; line_num = 10'd22;
    @(negedge clk);
    line_start = 1'b0;
    check(data_active == 1'b0, "R10 burst ended", data_active, 0);
    repeat (5) @(negedge clk);
    check(data_active == 1'b0 && level_hi == 1'b0, "R10 stays idle", data_active, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule